// File: doc/BRIEF.md
# I2C Transaction Sequencer with Packed Error Reporting

This block turns one command into a complete I2C transaction on a byte-level controller. The controller is reached through a small register-style port. The block drives that port step by step and supports three kinds of transaction:

- A probe checks whether a chip answers.
- A write sends the chip address, up to `MADDR_BYTES` memory-address bytes and a run of data bytes.
- A random read sends a write-direction address phase, then a repeated START, then reads a run of bytes.

After every step the block polls the controller's completion flag at a fixed interval. It compares the returned status code with the code that step should produce. The poll interval is one SCL period, derived from `CLK_HZ / SCL_HZ`.

The first status mismatch or timeout ends the byte steps. The STOP condition is still issued in every case, and the block then waits for the idle status. Completion is one `done` pulse with a 32-bit result word. The word is zero on success. Otherwise it holds:

- the error class in bits 31..24;
- the control byte of the failing step in bits 23..16;
- the status observed in bits 15..8;
- the expected status in bits 7..0.

Write data is pulled one byte per `wr_pop`. Read data leaves as `rd_valid`/`rd_data` pulses.

Top module: `i2c_txn_seq`

## Requirements
- R1: After reset the block is idle: `cmd_ready` is 1, and `done`, `rd_valid`, `wr_pop` and `eng_ctrl_wr` are all 0.
- R2: The controller's control-byte bits are ACK = 0x04, flag = 0x08, STOP = 0x10, START = 0x20 and enable = 0x40. A write (op 1) runs these steps in order:
  - START (control 0x60), expecting 0x08.
  - The address byte `{chip,0}`, written with control 0x40, expecting 0x18.
  - `cmd_alen` memory-address bytes, most significant first, each expecting 0x28.
  - `cmd_len` bytes taken from `wr_data` on `wr_pop`, each expecting 0x28.
  - STOP (control 0x50).
- R3: A random read (op 2) sends START (expecting 0x08), then `{chip,0}` (expecting 0x18), then the memory-address bytes. It then issues a repeated START (control 0x60, expecting 0x10) with no STOP in between, followed by `{chip,1}` expecting 0x40.
- R4: In a read, every data byte except the last is launched with control 0x44 and expects 0x50. The last byte is launched with control 0x40 and expects 0x58. Each byte received is presented once on `rd_valid`/`rd_data`, in bus order.
- R5: A probe (op 0) runs these steps: START expecting 0x08, `{chip,1}` expecting 0x40, one byte launched with control 0x40 expecting 0x58, then STOP. It never asserts `rd_valid`.
- R6: When the flag is seen with a status other than the expected one, the result word is {0x01, step control | 0x08, observed status, expected status}.
- R7: When the flag stays low for `POLL_LIMIT` polls spaced `CLK_HZ/SCL_HZ` cycles apart, the result word is {0x02, step control, last status, expected status}. Such a transaction takes at least `POLL_LIMIT*CLK_HZ/SCL_HZ` cycles.
- R8: Only the first failure is reported. After it, no further byte or START step is issued. The next controller write is the STOP.
- R9: STOP is issued after every transaction, and completion waits for status 0xF8. If 0xF8 never appears within the poll limit and no earlier error exists, the word is {0x02, 0x50, last status, 0xF8}.
- R10: `done` is a single-cycle pulse. On success `err_word` is zero while `done` is high.
- R11: With `cmd_alen` = 0 no memory-address byte is sent. A read with `cmd_len` = 0 goes to STOP right after the read-direction address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command present; taken when `cmd_ready` is high |
| cmd_ready | output | 1 | Block idle, accepts a command |
| cmd_op | input | 2 | 0 = probe, 1 = write, 2 = random read |
| cmd_chip | input | 7 | 7-bit chip address |
| cmd_alen | input | ALEN_W | Number of memory-address bytes (0..`MADDR_BYTES`) |
| cmd_maddr | input | 8*MADDR_BYTES | Memory address |
| cmd_len | input | LEN_W | Data byte count |
| wr_data | input | 8 | Next write byte, consumed on `wr_pop` |
| wr_pop | output | 1 | Takes `wr_data` this cycle |
| rd_valid | output | 1 | Received byte valid |
| rd_data | output | 8 | Received byte |
| done | output | 1 | Transaction finished (one cycle) |
| err_word | output | 32 | Result word, valid with `done` |
| eng_ctrl_wr | output | 1 | Control write strobe to the controller |
| eng_ctrl | output | 8 | Control byte |
| eng_data_wr | output | 1 | Data register write strobe |
| eng_wdata | output | 8 | Byte to transmit |
| eng_flag | input | 1 | Controller completion flag |
| eng_status | input | 8 | Controller status code |
| eng_rdata | input | 8 | Controller received byte |

## Verification
The assertions assume that the controller clears its flag on every control write and does not raise it again sooner than one cycle later. They also assume that `eng_status` and `eng_rdata` are stable while the flag is high, and that `cmd_alen` never exceeds `MADDR_BYTES`.

The bench's controller model meets these assumptions. It raises the flag two cycles after each launch, well inside one poll period, and updates status and flag together. Commands are applied only while `cmd_ready` is high, with address lengths inside the legal range. Faults are injected only through the model's responses: an absent chip, a refused data byte, a flag that never rises, or an idle status that never appears.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

    typedef enum logic [1:0] {
        OP_PROBE = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2
    } op_e;

    // control byte bits decoded by the byte engine
    localparam logic [7:0] CTL_ACK   = 8'h04;
    localparam logic [7:0] CTL_FLAG  = 8'h08;
    localparam logic [7:0] CTL_STOP  = 8'h10;
    localparam logic [7:0] CTL_START = 8'h20;
    localparam logic [7:0] CTL_EN    = 8'h40;

    // status codes returned by the engine
    localparam logic [7:0] SC_START   = 8'h08;
    localparam logic [7:0] SC_RESTART = 8'h10;
    localparam logic [7:0] SC_AW_ACK  = 8'h18;
    localparam logic [7:0] SC_DW_ACK  = 8'h28;
    localparam logic [7:0] SC_AR_ACK  = 8'h40;
    localparam logic [7:0] SC_DR_ACK  = 8'h50;
    localparam logic [7:0] SC_DR_NAK  = 8'h58;
    localparam logic [7:0] SC_IDLE    = 8'hF8;

    localparam logic [7:0] ERR_MISMATCH = 8'h01;
    localparam logic [7:0] ERR_TIMEOUT  = 8'h02;

    typedef enum logic [1:0] {
        S_IDLE,
        S_ISSUE,
        S_WAIT,
        S_FIN
    } state_e;

    typedef enum logic [2:0] {
        P_START1,
        P_ADDR1,
        P_MADDR,
        P_WDATA,
        P_START2,
        P_ADDR2,
        P_RDATA,
        P_STOP
    } phase_e;

endpackage

// File: rtl/i2cseq_poll_timer.sv
module i2cseq_poll_timer #(
    parameter int POLL_CYC   = 1000,
    parameter int POLL_LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic tick,
    output logic last
);
    localparam int DIV_W = (POLL_CYC   > 1) ? $clog2(POLL_CYC)       : 1;
    localparam int CNT_W = $clog2(POLL_LIMIT + 1);

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        tick  = run && (tmr_q.div == '0);
        last  = tick && (tmr_q.cnt == CNT_W'(POLL_LIMIT - 1));
        if (restart) begin
            tmr_d.div = DIV_W'(POLL_CYC - 1);
            tmr_d.cnt = '0;
        end else if (tick) begin
            tmr_d.div = DIV_W'(POLL_CYC - 1);
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end else if (run) begin
            tmr_d.div = tmr_q.div - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    // R7
    poll_count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (tmr_q.cnt < CNT_W'(POLL_LIMIT)));

    // R7
    poll_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !restart) |=> !tick);

endmodule

// File: rtl/i2cseq_step_judge.sv
module i2cseq_step_judge
    import i2cseq_pkg::*;
(
    input  logic        idle_mode,
    input  logic        tick,
    input  logic        last,
    input  logic        flag,
    input  logic [7:0]  status,
    input  logic [7:0]  expected,
    input  logic [7:0]  ctrl,
    output logic        pass,
    output logic        fail,
    output logic [31:0] word
);
    logic [7:0] ctrl_seen;
    logic [7:0] err_class;

    always_comb begin
        ctrl_seen = ctrl | (flag ? CTL_FLAG : 8'h00);
        if (idle_mode) begin
            pass      = tick && (status == SC_IDLE);
            fail      = tick && last && (status != SC_IDLE);
            err_class = ERR_TIMEOUT;
        end else begin
            pass      = tick && flag && (status == expected);
            fail      = tick && ((flag && (status != expected)) || (!flag && last));
            err_class = flag ? ERR_MISMATCH : ERR_TIMEOUT;
        end
        word = {err_class, ctrl_seen, status, expected};
    end

endmodule

// File: rtl/i2c_txn_seq.sv
module i2c_txn_seq
    import i2cseq_pkg::*;
#(
    parameter int CLK_HZ      = 100_000_000,
    parameter int SCL_HZ      = 100_000,
    parameter int POLL_LIMIT  = 1000,
    parameter int MADDR_BYTES = 3,
    parameter int LEN_W       = 8,
    localparam int ALEN_W     = $clog2(MADDR_BYTES + 1),
    localparam int MA_W       = 8 * MADDR_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_op,
    input  logic [6:0]        cmd_chip,
    input  logic [ALEN_W-1:0] cmd_alen,
    input  logic [MA_W-1:0]   cmd_maddr,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic [7:0]        wr_data,
    output logic              wr_pop,
    output logic              rd_valid,
    output logic [7:0]        rd_data,
    output logic              done,
    output logic [31:0]       err_word,
    output logic              eng_ctrl_wr,
    output logic [7:0]        eng_ctrl,
    output logic              eng_data_wr,
    output logic [7:0]        eng_wdata,
    input  logic              eng_flag,
    input  logic [7:0]        eng_status,
    input  logic [7:0]        eng_rdata
);
    localparam int POLL_CYC = (CLK_HZ / SCL_HZ > 0) ? CLK_HZ / SCL_HZ : 1;

    typedef struct packed {
        state_e            st;
        phase_e            ph;
        logic [1:0]        op;
        logic [6:0]        chip;
        logic [ALEN_W-1:0] alen;
        logic [MA_W-1:0]   maddr;
        logic [LEN_W-1:0]  len;
        logic [7:0]        ctrl_last;
        logic [7:0]        expect_sc;
        logic [31:0]       err;
        logic              rdv;
        logic [7:0]        rdd;
    } seq_t;

    seq_t seq_d, seq_q;

    logic        is_read, is_probe;
    logic [7:0]  step_ctrl, step_byte, step_exp, mbyte;
    logic        step_has_data;
    logic        issue, waiting;
    logic        tick, last, pass, fail;
    logic [31:0] fail_word;
    phase_e      after_maddr;

    assign is_read  = (seq_q.op == OP_READ);
    assign is_probe = (seq_q.op == OP_PROBE);
    assign issue    = (seq_q.st == S_ISSUE);
    assign waiting  = (seq_q.st == S_WAIT);

    i2cseq_poll_timer #(
        .POLL_CYC   (POLL_CYC),
        .POLL_LIMIT (POLL_LIMIT)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (issue),
        .run     (waiting),
        .tick    (tick),
        .last    (last)
    );

    i2cseq_step_judge u_judge (
        .idle_mode (seq_q.ph == P_STOP),
        .tick      (tick),
        .last      (last),
        .flag      (eng_flag),
        .status    (eng_status),
        .expected  (seq_q.expect_sc),
        .ctrl      (seq_q.ctrl_last),
        .pass      (pass),
        .fail      (fail),
        .word      (fail_word)
    );

    // memory address byte selected by remaining count (MSB first)
    always_comb begin
        mbyte = 8'h00;
        for (int i = 0; i < MADDR_BYTES; i++) begin
            if (seq_q.alen == ALEN_W'(i + 1)) mbyte = seq_q.maddr[8*i +: 8];
        end
    end

    // per-phase step description
    always_comb begin
        step_ctrl     = CTL_EN;
        step_byte     = 8'h00;
        step_exp      = SC_IDLE;
        step_has_data = 1'b0;
        unique case (seq_q.ph)
            P_START1: begin step_ctrl = CTL_EN | CTL_START; step_exp = SC_START; end
            P_ADDR1: begin
                step_byte     = {seq_q.chip, is_probe};
                step_exp      = is_probe ? SC_AR_ACK : SC_AW_ACK;
                step_has_data = 1'b1;
            end
            P_MADDR: begin step_byte = mbyte;   step_exp = SC_DW_ACK; step_has_data = 1'b1; end
            P_WDATA: begin step_byte = wr_data; step_exp = SC_DW_ACK; step_has_data = 1'b1; end
            P_START2: begin step_ctrl = CTL_EN | CTL_START; step_exp = SC_RESTART; end
            P_ADDR2: begin
                step_byte     = {seq_q.chip, 1'b1};
                step_exp      = SC_AR_ACK;
                step_has_data = 1'b1;
            end
            P_RDATA: begin
                if (seq_q.len > LEN_W'(1)) begin
                    step_ctrl = CTL_EN | CTL_ACK;
                    step_exp  = SC_DR_ACK;
                end else begin
                    step_exp  = SC_DR_NAK;
                end
            end
            P_STOP: begin step_ctrl = CTL_EN | CTL_STOP; step_exp = SC_IDLE; end
            default: ;
        endcase
    end

    // what follows the memory address phase
    always_comb begin
        if (is_read)                  after_maddr = P_START2;
        else if (seq_q.len != '0)     after_maddr = P_WDATA;
        else                          after_maddr = P_STOP;
    end

    always_comb begin
        seq_d     = seq_q;
        seq_d.rdv = 1'b0;
        unique case (seq_q.st)
            S_IDLE: begin
                if (cmd_valid) begin
                    seq_d.st    = S_ISSUE;
                    seq_d.ph    = P_START1;
                    seq_d.op    = cmd_op;
                    seq_d.chip  = cmd_chip;
                    seq_d.alen  = cmd_alen;
                    seq_d.maddr = cmd_maddr;
                    seq_d.len   = (cmd_op == OP_PROBE) ? LEN_W'(1) : cmd_len;
                    seq_d.err   = '0;
                end
            end
            S_ISSUE: begin
                seq_d.st        = S_WAIT;
                seq_d.ctrl_last = step_ctrl;
                seq_d.expect_sc = step_exp;
            end
            S_WAIT: begin
                if (fail) begin
                    if (seq_q.err == '0) seq_d.err = fail_word;
                    if (seq_q.ph == P_STOP) begin
                        seq_d.st = S_FIN;
                    end else begin
                        seq_d.ph = P_STOP;
                        seq_d.st = S_ISSUE;
                    end
                end else if (pass) begin
                    seq_d.st = S_ISSUE;
                    unique case (seq_q.ph)
                        P_START1: seq_d.ph = P_ADDR1;
                        P_ADDR1: begin
                            if (is_probe)                seq_d.ph = P_RDATA;
                            else if (seq_q.alen != '0)   seq_d.ph = P_MADDR;
                            else                         seq_d.ph = after_maddr;
                        end
                        P_MADDR: begin
                            seq_d.alen = seq_q.alen - 1'b1;
                            if (seq_q.alen == ALEN_W'(1)) seq_d.ph = after_maddr;
                        end
                        P_WDATA: begin
                            seq_d.len = seq_q.len - 1'b1;
                            if (seq_q.len == LEN_W'(1)) seq_d.ph = P_STOP;
                        end
                        P_START2: seq_d.ph = P_ADDR2;
                        P_ADDR2:  seq_d.ph = (seq_q.len != '0) ? P_RDATA : P_STOP;
                        P_RDATA: begin
                            seq_d.rdv = is_read;
                            seq_d.rdd = eng_rdata;
                            seq_d.len = seq_q.len - 1'b1;
                            if (seq_q.len == LEN_W'(1)) seq_d.ph = P_STOP;
                        end
                        P_STOP: seq_d.st = S_FIN;
                        default: ;
                    endcase
                end
            end
            S_FIN:   seq_d.st = S_IDLE;
            default: seq_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q    <= '0;
            seq_q.st <= S_IDLE;
            seq_q.ph <= P_START1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign cmd_ready   = (seq_q.st == S_IDLE);
    assign done        = (seq_q.st == S_FIN);
    assign err_word    = seq_q.err;
    assign rd_valid    = seq_q.rdv;
    assign rd_data     = seq_q.rdd;
    assign eng_ctrl_wr = issue;
    assign eng_ctrl    = issue ? step_ctrl : 8'h00;
    assign eng_data_wr = issue && step_has_data;
    assign eng_wdata   = issue ? step_byte : 8'h00;
    assign wr_pop      = issue && (seq_q.ph == P_WDATA);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    fin_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(waiting && seq_q.ph == P_STOP));

    // R8
    stop_after_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_ctrl_wr && err_word != '0) |-> (eng_ctrl == (CTL_EN | CTL_STOP)));

    // R4
    ack_only_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_ctrl_wr && eng_ctrl[2]) |-> (is_read && !eng_data_wr));

    // R2
    pop_with_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pop |-> (eng_data_wr && eng_ctrl == CTL_EN));

    // R6
    err_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_word != '0) |-> (err_word[31:24] == ERR_MISMATCH || err_word[31:24] == ERR_TIMEOUT));

    // R5
    probe_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid) |-> $past(is_read));

endmodule

// File: tb/i2c_txn_seq_bench.sv
module i2c_txn_seq_bench;

    localparam int CLK_HZ     = 400_000;
    localparam int SCL_HZ     = 100_000;
    localparam int POLL_LIMIT = 5;
    localparam int POLL_CYC   = CLK_HZ / SCL_HZ;
    localparam int MADDR_B    = 3;
    localparam int LEN_W      = 8;
    localparam int ALEN_W     = $clog2(MADDR_B + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic              cmd_valid = 1'b0;
    logic              cmd_ready;
    logic [1:0]        cmd_op = '0;
    logic [6:0]        cmd_chip = '0;
    logic [ALEN_W-1:0] cmd_alen = '0;
    logic [8*MADDR_B-1:0] cmd_maddr = '0;
    logic [LEN_W-1:0]  cmd_len = '0;
    logic [7:0]        wr_data;
    logic              wr_pop, rd_valid, done;
    logic [7:0]        rd_data;
    logic [31:0]       err_word;
    logic              eng_ctrl_wr, eng_data_wr;
    logic [7:0]        eng_ctrl, eng_wdata;
    logic              eng_flag;
    logic [7:0]        eng_status, eng_rdata;

    i2c_txn_seq #(
        .CLK_HZ(CLK_HZ), .SCL_HZ(SCL_HZ), .POLL_LIMIT(POLL_LIMIT),
        .MADDR_BYTES(MADDR_B), .LEN_W(LEN_W)
    ) u_i2c_txn_seq (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_chip(cmd_chip), .cmd_alen(cmd_alen), .cmd_maddr(cmd_maddr), .cmd_len(cmd_len),
        .wr_data(wr_data), .wr_pop(wr_pop), .rd_valid(rd_valid), .rd_data(rd_data),
        .done(done), .err_word(err_word),
        .eng_ctrl_wr(eng_ctrl_wr), .eng_ctrl(eng_ctrl), .eng_data_wr(eng_data_wr),
        .eng_wdata(eng_wdata), .eng_flag(eng_flag), .eng_status(eng_status), .eng_rdata(eng_rdata)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    string cur_tag = "R1";

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // ---------------- byte engine model ----------------
    logic [7:0] wbuf [16];
    logic [3:0] wr_idx = '0;
    assign wr_data = wbuf[wr_idx];
    always @(posedge clk) if (wr_pop) wr_idx <= wr_idx + 1'b1;

    bit   present = 1;
    int   nak_idx = -1;
    int   hang_abs = -1;
    bit   stop_hang = 0;
    int   gops = 0;
    int   dcnt = 0;
    int   rcnt = 0;
    int   dly = 0;
    bit   pend = 0, pend_flag = 0, in_txn = 0, addr_next = 0, reading = 0;
    logic [7:0] pend_st = 8'h00;
    logic       e_flag = 1'b0;
    logic [7:0] e_stat = 8'hF8;
    logic [7:0] e_rd = 8'h00;
    assign eng_flag = e_flag;
    assign eng_status = e_stat;
    assign eng_rdata = e_rd;

    always @(posedge clk) begin
        if (eng_ctrl_wr) begin
            gops   <= gops + 1;
            e_flag <= 1'b0;
            dly    <= 1;
            if (eng_ctrl[4]) begin
                pend <= !stop_hang; pend_flag <= 0; pend_st <= 8'hF8; in_txn <= 0;
            end else begin
                pend <= (gops != hang_abs);
                pend_flag <= 1;
                if (eng_ctrl[5]) begin
                    pend_st <= in_txn ? 8'h10 : 8'h08;
                    in_txn <= 1; addr_next <= 1; dcnt <= 0;
                end else if (addr_next) begin
                    addr_next <= 0;
                    reading <= eng_wdata[0];
                    pend_st <= present ? (eng_wdata[0] ? 8'h40 : 8'h18)
                                       : (eng_wdata[0] ? 8'h48 : 8'h20);
                end else if (reading) begin
                    pend_st <= eng_ctrl[2] ? 8'h50 : 8'h58;
                    e_rd <= 8'hA0 + 8'(rcnt);
                    rcnt <= rcnt + 1;
                end else begin
                    pend_st <= (dcnt == nak_idx) ? 8'h30 : 8'h28;
                    dcnt <= dcnt + 1;
                end
            end
        end else if (pend) begin
            if (dly == 0) begin
                e_stat <= pend_st; e_flag <= pend_flag; pend <= 0;
            end else dly <= dly - 1;
        end
    end

    // ---------------- scoreboard ----------------
    logic [16:0] exp_ops [$];
    logic [7:0]  exp_rd [$];
    logic [31:0] exp_done [$];

    always @(negedge clk) if (rst_n) begin
        if (eng_ctrl_wr) begin
            logic [16:0] got, e;
            got = {eng_data_wr, eng_ctrl, eng_data_wr ? eng_wdata : 8'h00};
            if (exp_ops.size() == 0) chk(0, {cur_tag, " unexpected engine write"}, 32'(got), 0);
            else begin e = exp_ops.pop_front(); chk(got == e, {cur_tag, " engine step"}, 32'(got), 32'(e)); end
        end
        if (rd_valid) begin
            logic [7:0] e;
            if (exp_rd.size() == 0) chk(0, "R4 R5 unexpected rd_valid", 32'(rd_data), 0);
            else begin e = exp_rd.pop_front(); chk(rd_data == e, "R4 read byte", 32'(rd_data), 32'(e)); end
        end
        if (done) begin
            logic [31:0] e;
            if (exp_done.size() == 0) chk(0, {cur_tag, " unexpected done"}, err_word, 0);
            else begin e = exp_done.pop_front(); chk(err_word == e, {cur_tag, " result word"}, err_word, e); end
        end
    end

    // ---------------- reference model / driver ----------------
    logic [31:0] ref_err;
    int          ref_k;
    logic [7:0]  last_st = 8'hF8;
    int          rctr = 0;
    int          hang_rel = -1;

    task automatic push_step(input logic [7:0] ctrl, input bit dwr, input logic [7:0] data,
                             input logic [7:0] expd, input logic [7:0] act);
        if (ref_err != 0) return;
        exp_ops.push_back({dwr, ctrl, dwr ? data : 8'h00});
        if (ref_k == hang_rel) ref_err = {8'h02, ctrl, last_st, expd};
        else begin
            last_st = act;
            if (act != expd) ref_err = {8'h01, ctrl | 8'h08, act, expd};
        end
        ref_k++;
    endtask

    task automatic run_txn(input string tag, input int op, input logic [6:0] chip, input int alen,
                           input logic [23:0] maddr, input int len, input bit pres,
                           input int nak, input int hang, input bit shang, input bit timed);
        int dc;
        int cyc;
        bit rw;
        logic [7:0] b;
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cur_tag = tag;
        present = pres; nak_idx = nak; stop_hang = shang;
        hang_abs = (hang >= 0) ? gops + hang : -1;
        hang_rel = hang;
        for (int i = 0; i < 16; i++) wbuf[wr_idx + 4'(i)] = 8'h30 + 8'(i * 7);
        ref_err = 0; ref_k = 0; dc = 0;
        rw = (op == 0);
        push_step(8'h60, 0, 0, 8'h08, 8'h08);
        push_step(8'h40, 1, {chip, rw}, rw ? 8'h40 : 8'h18,
                  pres ? (rw ? 8'h40 : 8'h18) : (rw ? 8'h48 : 8'h20));
        if (op == 0) begin
            if (ref_err == 0) begin rctr++; push_step(8'h40, 0, 0, 8'h58, 8'h58); end
        end else begin
            for (int i = alen - 1; i >= 0; i--) if (ref_err == 0) begin
                push_step(8'h40, 1, maddr[8*i +: 8], 8'h28, (dc == nak) ? 8'h30 : 8'h28);
                dc++;
            end
            if (op == 1) begin
                for (int i = 0; i < len; i++) if (ref_err == 0) begin
                    push_step(8'h40, 1, wbuf[wr_idx + 4'(i)], 8'h28, (dc == nak) ? 8'h30 : 8'h28);
                    dc++;
                end
            end else begin
                push_step(8'h60, 0, 0, 8'h10, 8'h10);
                push_step(8'h40, 1, {chip, 1'b1}, 8'h40, pres ? 8'h40 : 8'h48);
                for (int i = 0; i < len; i++) if (ref_err == 0) begin
                    bit ack;
                    ack = (i < len - 1);
                    b = 8'hA0 + 8'(rctr);
                    rctr++;
                    push_step(ack ? 8'h44 : 8'h40, 0, 0, ack ? 8'h50 : 8'h58, ack ? 8'h50 : 8'h58);
                    if (ref_err == 0) exp_rd.push_back(b);
                end
            end
        end
        exp_ops.push_back({1'b0, 8'h50, 8'h00});
        if (shang) begin
            if (ref_err == 0) ref_err = {8'h02, 8'h50, last_st, 8'hF8};
        end else last_st = 8'hF8;
        exp_done.push_back(ref_err);

        cmd_valid = 1; cmd_op = 2'(op); cmd_chip = chip; cmd_alen = ALEN_W'(alen);
        cmd_maddr = maddr; cmd_len = LEN_W'(len);
        @(negedge clk);
        cmd_valid = 0;
        cyc = 1;
        while (!done) begin @(negedge clk); cyc++; end
        if (timed) chk(cyc >= POLL_LIMIT * POLL_CYC, "R7 timeout duration", 32'(cyc), 32'(POLL_LIMIT * POLL_CYC));
        @(negedge clk);
        chk(!done, "R10 done single cycle", 32'(done), 0);
        chk(exp_ops.size() == 0, {tag, " all steps seen"}, 32'(exp_ops.size()), 0);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(cmd_ready == 1'b1, "R1 ready after reset", 32'(cmd_ready), 1);
        chk(done == 1'b0, "R1 done low", 32'(done), 0);
        chk(eng_ctrl_wr == 1'b0 && wr_pop == 1'b0, "R1 no engine activity", 32'({eng_ctrl_wr, wr_pop}), 0);
        chk(rd_valid == 1'b0, "R1 no read data", 32'(rd_valid), 0);
        rst_n = 1;
        repeat (2) @(negedge clk);

        run_txn("R2 write",         1, 7'h50, 2, 24'h001234, 3, 1, -1, -1, 0, 0);
        run_txn("R3 random read",   2, 7'h50, 2, 24'h000456, 3, 1, -1, -1, 0, 0);
        run_txn("R5 probe",         0, 7'h21, 0, 24'h0,      0, 1, -1, -1, 0, 0);
        run_txn("R6 probe absent",  0, 7'h22, 0, 24'h0,      0, 0, -1, -1, 0, 0);
        run_txn("R8 data nak",      1, 7'h33, 1, 24'h0000AB, 2, 1,  1, -1, 0, 0);
        run_txn("R7 flag timeout",  1, 7'h44, 1, 24'h0000CD, 1, 1, -1,  2, 0, 1);
        run_txn("R9 stop timeout",  1, 7'h45, 1, 24'h000011, 1, 1, -1, -1, 1, 1);
        run_txn("R8 err then stop", 2, 7'h46, 1, 24'h000022, 2, 0, -1, -1, 1, 0);
        run_txn("R11 no maddr",     1, 7'h47, 0, 24'h0,      1, 1, -1, -1, 0, 0);
        run_txn("R11 read len0",    2, 7'h48, 0, 24'h0,      0, 1, -1, -1, 0, 0);
        run_txn("R4 read one",      2, 7'h49, 1, 24'h000077, 1, 1, -1, -1, 0, 0);
        run_txn("R2 three maddr",   1, 7'h4A, 3, 24'hC0FFEE, 2, 1, -1, -1, 0, 0);
        run_txn("R6 read wrong ack",2, 7'h4B, 1, 24'h000099, 2, 1,  0, -1, 0, 0);

        chk(exp_rd.size() == 0, "R4 all read bytes seen", 32'(exp_rd.size()), 0);
        chk(exp_done.size() == 0, "R10 all completions seen", 32'(exp_done.size()), 0);
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule